// File: doc/BRIEF.md
# Dual-Bank Sample Output Demultiplexer

This block sits between a converter core and the output pins of a high-rate sampler. It takes one word per clock, together with a qualifying valid flag. After a fixed delay it places each word on one of two output banks, A or B. Two mode-select inputs choose the bank layout:
- everything on bank A;
- words alternating between the banks;
- pairs presented on both banks at once.

A divide-by-two phase bit decides which bank a word goes to. A dedicated realign input clears that phase, so the user can fix which bank receives a given sample.

A true/complement output clock pair comes with the banks. In single-bank mode it strobes every fresh bank-A word. In the two-bank layouts it shows which half of a pair was last written. A power-down input drops the output-enable controls, which in the pad ring put the banks and the clock pair into high impedance.

Top module: `adc_bank_demux`

## Requirements
- R1: The mode inputs {mode_sel1, mode_sel2} are decoded as follows: 2'b00 is paired output, 2'b01 is alternating output, and 2'b10 or 2'b11 is single-bank output.
- R2: In alternating mode, valid words go to bank A and bank B in turn, starting with bank A after any reset. A word presented before clock edge n appears on its bank after edge n+3. Both banks never change on the same edge.
- R3: In paired mode, the first word of a pair is held internally and changes neither bank. The second word is written to bank B after edge n+3. On that same edge its partner is written to bank A, so bank A lags its own sample by one more clock.
- R4: In single-bank mode, every valid word is written to bank A after edge n+3, and bank B keeps its value.
- R5: A cycle with smp_valid low writes no bank and does not advance the bank phase.
- R6: In either two-bank mode, phase_rst high at an edge discards the word that reaches the steering stage at that edge. It clears the phase and the pair hold register, so the next valid word goes to bank A, and it drives oclk_p low.
- R7: In single-bank mode, phase_rst has no effect, and the phase stays frozen.
- R8: oclk_n is always the complement of oclk_p. In single-bank mode, oclk_p is high for exactly the cycle after each bank-A write and low otherwise. In the two-bank modes, each valid steering edge loads oclk_p with the phase that word used: 0 for a bank-A word or the first word of a pair, 1 for a bank-B word or a completed pair. oclk_p holds between those edges.
- R9: oe_data and oe_clk equal the inverse of pwr_down as sampled at the previous edge.
- R10: While rst is high, both banks read 0, oclk_p reads 0, oclk_n reads 1, both enables read 0, and the phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel1 | input | 1 | Mode select, upper bit |
| mode_sel2 | input | 1 | Mode select, lower bit |
| phase_rst | input | 1 | Bank-phase realign, used in two-bank modes only |
| pwr_down | input | 1 | Power-down request |
| smp_valid | input | 1 | Qualifies smp_data this cycle |
| smp_data | input | SMP_W | Word from the converter core |
| bank_a | output | SMP_W | Output bank A |
| bank_b | output | SMP_W | Output bank B |
| oclk_p | output | 1 | Output clock, true |
| oclk_n | output | 1 | Output clock, complement |
| oe_data | output | 1 | Enable for both data banks |
| oe_clk | output | 1 | Enable for the clock pair |

## Verification
The stimulus is an incrementing word stream, so any word that is dropped, duplicated or sent to the wrong bank gives a value that cannot be mistaken. The stream is applied in every layout, including both encodings of single-bank mode. A gapped valid pattern separates "advance phase on valid words" from "advance phase every clock". Realign pulses in the middle of a stream separate a correct phase clear from a stale phase, and in paired mode from a stale partner word. The same pulse in single-bank mode must leave the stream untouched. Comparing every cycle exposes the one-clock lag between the banks in paired mode and the exact edge on which each oclk_p level appears.

// File: rtl/adc_demux_pkg.sv
`timescale 1ns/1ps
package adc_demux_pkg;

  typedef enum logic [1:0] {
    OM_PAR = 2'd0,
    OM_ILV = 2'd1,
    OM_ONE = 2'd2
  } out_mode_e;

  // Upper select bit wins: single bank regardless of the lower bit.
  function automatic out_mode_e decode_mode(input logic sel1, input logic sel2);
    if (sel1)      return OM_ONE;
    else if (sel2) return OM_ILV;
    else           return OM_PAR;
  endfunction

endpackage

// File: rtl/adc_demux_pipe.sv
`timescale 1ns/1ps
module adc_demux_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic         v;
      logic [W-1:0] d;
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) v <= 1'b0;
          else     v <= in_valid;
          d <= in_data;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) v <= 1'b0;
          else     v <= g_stage[i-1].v;
          d <= g_stage[i-1].d;
        end
      end
    end
  endgenerate

  assign out_valid = g_stage[DEPTH-1].v;
  assign out_data  = g_stage[DEPTH-1].d;

endmodule

// File: rtl/adc_demux_phase.sv
`timescale 1ns/1ps
module adc_demux_phase (
  input  logic clk,
  input  logic rst,
  input  logic dual,
  input  logic realign,
  input  logic advance,
  output logic phase
);

  always_ff @(posedge clk) begin
    if (rst)                      phase <= 1'b0;
    else if (dual && realign)     phase <= 1'b0;
    else if (dual && advance)     phase <= ~phase;
  end

  // R6: realign in a two-bank mode leaves the phase at bank A
  p_realign_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (dual && realign) |=> !phase);

  // R7: single-bank operation freezes the phase
  p_phase_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (!dual && !rst) |=> $stable(phase));

endmodule

// File: rtl/adc_demux_steer.sv
`timescale 1ns/1ps
module adc_demux_steer
  import adc_demux_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  out_mode_e    mode,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         phase,
  input  logic         realign,
  output logic [W-1:0] bank_a,
  output logic [W-1:0] bank_b,
  output logic         oclk_p,
  output logic         oclk_n
);

  logic         dual;
  logic         clr;
  logic [W-1:0] hold_q;

  assign dual = (mode != OM_ONE);
  assign clr  = dual && realign;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_a <= '0;
      bank_b <= '0;
      hold_q <= '0;
      oclk_p <= 1'b0;
      oclk_n <= 1'b1;
    end else if (clr) begin
      hold_q <= '0;
      oclk_p <= 1'b0;
      oclk_n <= 1'b1;
    end else begin
      case (mode)
        OM_ONE: begin
          if (in_valid) bank_a <= in_data;
          oclk_p <= in_valid;
          oclk_n <= !in_valid;
        end
        OM_ILV: begin
          if (in_valid) begin
            if (!phase) bank_a <= in_data;
            else        bank_b <= in_data;
            oclk_p <= phase;
            oclk_n <= !phase;
          end
        end
        OM_PAR: begin
          if (in_valid) begin
            if (!phase) begin
              hold_q <= in_data;
            end else begin
              bank_a <= hold_q;
              bank_b <= in_data;
            end
            oclk_p <= phase;
            oclk_n <= !phase;
          end
        end
        default: begin
        end
      endcase
    end
  end

  // R8: the clock pair stays complementary
  p_oclk_pair_r8: assert property (@(posedge clk) disable iff (rst)
    oclk_n == !oclk_p);

  // R8: no strobe without a bank-A write in single-bank mode
  p_strobe_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!rst && mode == OM_ONE && !in_valid) |=> !oclk_p);

  // R4: bank B untouched in single-bank mode
  p_b_hold_single_r4: assert property (@(posedge clk) disable iff (rst)
    (!rst && mode == OM_ONE) |=> $stable(bank_b));

  // R2: alternating mode never updates both banks together
  p_one_bank_ilv_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst && mode == OM_ILV) |=> ($stable(bank_a) || $stable(bank_b)));

  // R3: first word of a pair leaves both banks unchanged
  p_pair_first_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst && mode == OM_PAR && in_valid && !phase && !realign)
      |=> ($stable(bank_a) && $stable(bank_b)));

endmodule

// File: rtl/adc_bank_demux.sv
`timescale 1ns/1ps
module adc_bank_demux
  import adc_demux_pkg::*;
#(
  parameter int SMP_W     = 8,
  parameter int LAT_STAGE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel1,
  input  logic             mode_sel2,
  input  logic             phase_rst,
  input  logic             pwr_down,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  output logic [SMP_W-1:0] bank_a,
  output logic [SMP_W-1:0] bank_b,
  output logic             oclk_p,
  output logic             oclk_n,
  output logic             oe_data,
  output logic             oe_clk
);

  out_mode_e        mode_now;
  logic             dual;
  logic             lat_valid;
  logic [SMP_W-1:0] lat_data;
  logic             phase;
  logic             advance;

  assign mode_now = decode_mode(mode_sel1, mode_sel2);
  assign dual     = (mode_now != OM_ONE);
  assign advance  = lat_valid && !phase_rst;

  adc_demux_pipe #(.W(SMP_W), .DEPTH(LAT_STAGE)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .in_valid (smp_valid),
    .in_data  (smp_data),
    .out_valid(lat_valid),
    .out_data (lat_data)
  );

  adc_demux_phase u_phase (
    .clk    (clk),
    .rst    (rst),
    .dual   (dual),
    .realign(phase_rst),
    .advance(advance),
    .phase  (phase)
  );

  adc_demux_steer #(.W(SMP_W)) u_steer (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_now),
    .in_valid(lat_valid),
    .in_data (lat_data),
    .phase   (phase),
    .realign (phase_rst),
    .bank_a  (bank_a),
    .bank_b  (bank_b),
    .oclk_p  (oclk_p),
    .oclk_n  (oclk_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_data <= 1'b0;
      oe_clk  <= 1'b0;
    end else begin
      oe_data <= !pwr_down;
      oe_clk  <= !pwr_down;
    end
  end

  // R9: enables follow power-down one edge later
  p_oe_follow_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (oe_data == !$past(pwr_down) && oe_clk == !$past(pwr_down)));

endmodule

// File: tb/test_adc_bank_demux.sv
`timescale 1ns/1ps
module test_adc_bank_demux;

  localparam int W        = 8;
  localparam int WDOG_CYC = 20000;

  // scenario: [21:20] mode pins {sel1,sel2}, [19:16] valid mask (bit c%4),
  //           [15:8] realign cycle (255 = none), [7:0] stream length
  localparam logic [21:0] SCN [8] = '{
    {2'b00, 4'hF, 8'd255, 8'd16},   // R3 paired
    {2'b01, 4'hF, 8'd255, 8'd16},   // R2 alternating
    {2'b10, 4'hF, 8'd255, 8'd12},   // R4 single
    {2'b11, 4'hF, 8'd255, 8'd8},    // R1 single via 2'b11
    {2'b01, 4'h5, 8'd255, 8'd20},   // R5 gaps
    {2'b01, 4'hF, 8'd9,   8'd20},   // R6 alternating realign
    {2'b00, 4'h7, 8'd10,  8'd24},   // R6 paired realign with gaps
    {2'b10, 4'hF, 8'd7,   8'd16}    // R7 realign ignored
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_sel1 = 1'b0;
  logic         mode_sel2 = 1'b0;
  logic         phase_rst = 1'b0;
  logic         pwr_down = 1'b0;
  logic         smp_valid = 1'b0;
  logic [W-1:0] smp_data = '0;
  logic [W-1:0] bank_a, bank_b;
  logic         oclk_p, oclk_n, oe_data, oe_clk;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  adc_bank_demux #(.SMP_W(W), .LAT_STAGE(3)) i_adc_bank_demux (
    .clk(clk), .rst(rst), .mode_sel1(mode_sel1), .mode_sel2(mode_sel2),
    .phase_rst(phase_rst), .pwr_down(pwr_down), .smp_valid(smp_valid),
    .smp_data(smp_data), .bank_a(bank_a), .bank_b(bank_b),
    .oclk_p(oclk_p), .oclk_n(oclk_n), .oe_data(oe_data), .oe_clk(oe_clk)
  );

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int s);
    case (s)
      0: return "R3";
      1: return "R2";
      2: return "R4";
      3: return "R1";
      4: return "R5";
      5: return "R6";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_scn(input int s);
    logic [1:0]   md;
    logic [3:0]   mask;
    int           rat, len;
    logic         dual;
    logic         hv [64];
    logic [W-1:0] hd [64];
    logic [W-1:0] m_a, m_b, m_hold;
    logic         m_ph, m_oclk;
    string        tg;
    md   = SCN[s][21:20];
    mask = SCN[s][19:16];
    rat  = int'(SCN[s][15:8]);
    len  = int'(SCN[s][7:0]);
    dual = !md[1];
    tg   = tag_of(s);
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0; phase_rst = 1'b0;
    mode_sel1 = md[1]; mode_sel2 = md[0];
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_a = '0; m_b = '0; m_hold = '0; m_ph = 1'b0; m_oclk = 1'b0;
    for (int c = 0; c < len + 6; c++) begin
      hv[c] = (c < len) && mask[c % 4];
      hd[c] = W'(s * 32 + c + 1);
      smp_valid = hv[c];
      smp_data  = hd[c];
      phase_rst = (c == rat);
      @(posedge clk);
      // reference from the requirements: steering acts on the word from cycle c-3
      if (dual && (c == rat)) begin
        m_ph = 1'b0; m_hold = '0; m_oclk = 1'b0;
      end else if (c >= 3 && hv[c-3]) begin
        if (!dual) begin
          m_a = hd[c-3]; m_oclk = 1'b1;
        end else if (md[0]) begin
          if (!m_ph) m_a = hd[c-3]; else m_b = hd[c-3];
          m_oclk = m_ph; m_ph = !m_ph;
        end else begin
          if (!m_ph) m_hold = hd[c-3];
          else begin m_a = m_hold; m_b = hd[c-3]; end
          m_oclk = m_ph; m_ph = !m_ph;
        end
      end else if (!dual) begin
        m_oclk = 1'b0;
      end
      @(negedge clk);
      check(tg, "bank_a", bank_a, m_a);
      check(tg, "bank_b", bank_b, m_b);
      check("R8", "oclk_p", W'(oclk_p), W'(m_oclk));
      check("R8", "oclk_n", W'(oclk_n), W'(!m_oclk));
    end
    smp_valid = 1'b0;
    phase_rst = 1'b0;
  endtask

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10", "bank_a", bank_a, '0);
    check("R10", "bank_b", bank_b, '0);
    check("R10", "oclk_p", W'(oclk_p), W'(0));
    check("R10", "oclk_n", W'(oclk_n), W'(1));
    check("R10", "oe_data", W'(oe_data), W'(0));
    check("R10", "oe_clk", W'(oe_clk), W'(0));
    rst = 1'b0;
    for (int s = 0; s < 8; s++) run_scn(s);
    // R9 power-down directed test
    check("R9", "oe_data on", W'(oe_data), W'(1));
    pwr_down = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9", "oe_data off", W'(oe_data), W'(0));
    check("R9", "oe_clk off", W'(oe_clk), W'(0));
    pwr_down = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9", "oe_data back", W'(oe_data), W'(1));
    check("R9", "oe_clk back", W'(oe_clk), W'(1));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    #(WDOG_CYC * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule